// File: doc/BRIEF.md
# Paired Integer-to-Double Converter

The block turns a 64-bit source word holding two signed 32-bit integers into a 128-bit result holding two IEEE-754 double-precision values, one per lane. Because a double's 53-bit significand covers every 32-bit integer, each conversion is exact and no rounding or exception flags exist. As a side effect of a successful operation, the block reports the legacy floating-point stack state as reset: the 3-bit top pointer becomes 0 and the 16-bit tag word becomes all zeros (every register valid).

Before any result is produced, a fixed-priority gate examines the control and feature bits that travel with the operation, together with a pending-exception flag. If any of them blocks execution, the block reports a single fault code. The result is then zero, and the caller's stack state passes through unchanged.

Operations enter on a valid/ready stream and leave on a second valid/ready stream, one register stage apart. An input beat transfers when `in_valid` and `in_ready` are both high at a rising clock edge. The producer must hold the beat stable until that transfer. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure from `out_ready` reaches the input in the same cycle. While `out_valid` is high and `out_ready` is low, every output stays frozen.

Top module: `i2d_pair_cvt`

## Requirements
- R1: Source bits 31:0 convert into result bits 63:0, and source bits 63:32 convert into result bits 127:64. The lanes are independent.
- R2: Each result lane equals the signed lane integer exactly in IEEE-754 binary64 form (bit 63 sign, bits 62:52 biased exponent with bias 1023, bits 51:0 fraction). An input of 0 gives all-zero bits (+0.0).
- R3: The integer -2147483648 converts to sign 1, biased exponent 1054, fraction 0.
- R4: When the fault code is 0 (none), `out_stk_top` is 0 and `out_stk_tag` is 16'h0000.
- R5: When the pending-exception flag is set and no higher-priority fault applies, the fault code is 3. The result is all zero, and `out_stk_top`/`out_stk_tag` equal the values supplied with the beat.
- R6: The fault code is 1 (undefined operation) when the emulation bit is set, the extended-state-support bit is clear, or the double-precision SIMD feature bit is clear. As with every fault, the result is zero and the stack state passes through.
- R7: The fault code is 2 (device not available) when the task-switched bit is set and R6 does not apply. The result is zero and the stack state passes through.
- R8: Priority is fixed as code 1 over code 2 over code 3, and only one code is reported.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and all output data hold their values.
- R10: After reset `out_valid` is 0. A beat accepted at a clock edge appears on the outputs with `out_valid` high after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| in_src | input | 64 | Two packed signed 32-bit integers |
| in_emul | input | 1 | Emulation control bit |
| in_osxs | input | 1 | OS extended-state-support bit |
| in_feat | input | 1 | Double-precision SIMD feature bit |
| in_tsw | input | 1 | Task-switched control bit |
| in_fp_pend | input | 1 | Legacy floating-point exception pending |
| in_stk_top | input | 3 | Current stack top pointer |
| in_stk_tag | input | 16 | Current stack tag word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts output beat |
| out_res | output | 128 | Two packed doubles |
| out_stk_top | output | 3 | Updated stack top pointer |
| out_stk_tag | output | 16 | Updated stack tag word |
| out_fault | output | 2 | 0 none, 1 undefined, 2 device not available, 3 fp pending |

## Verification
The bench builds the block with its default parameters, two lanes of 32 bits each. These defaults make reachable the most negative integer, whose magnitude needs the 33rd bit, and every leading-one position from 0 to 31, that is, biased exponents 1023 through 1054. Random stalls on `out_ready` exercise the hold and back-pressure rules. Random control bits reach every fault combination, so priority is exercised.

// File: rtl/i2d_pkg.sv
package i2d_pkg;
  localparam int DP_W      = 64;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int DP_BIAS   = 1023;
  localparam int STK_TOP_W = 3;
  localparam int STK_TAG_W = 16;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_UNDEF  = 2'd1,
    FLT_NODEV  = 2'd2,
    FLT_FPPEND = 2'd3
  } flt_e;
endpackage

// File: rtl/i2d_lane.sv
module i2d_lane
  import i2d_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0] int_i,
  output logic [DP_W-1:0]  dbl_o
);
  localparam int MAG_W = INT_W + 1;
  localparam int IDX_W = $clog2(MAG_W);
  localparam int SIG_W = DP_FRAC_W + 1;

  logic                 neg;
  logic [MAG_W-1:0]     sx;
  logic [MAG_W-1:0]     mag;
  logic [IDX_W-1:0]     lead;
  logic [SIG_W-1:0]     wide;
  logic [SIG_W-1:0]     shifted;
  logic [5:0]           shamt;
  logic [DP_EXP_W-1:0]  expo;
  logic [DP_FRAC_W-1:0] frac;

  always_comb begin
    neg  = int_i[INT_W-1];
    sx   = {int_i[INT_W-1], int_i};
    mag  = neg ? (~sx + 1'b1) : sx;
    lead = '0;
    for (int i = 0; i < MAG_W; i++) begin
      if (mag[i]) lead = IDX_W'(i);
    end
    wide    = SIG_W'(mag);
    shamt   = 6'(DP_FRAC_W) - 6'(lead);
    shifted = wide << shamt;
    frac    = shifted[DP_FRAC_W-1:0];
    expo    = DP_EXP_W'(DP_BIAS) + DP_EXP_W'(lead);
    dbl_o   = (int_i == '0) ? '0 : {neg, expo, frac};
  end

  always_comb begin
    if (int_i == '0) begin
      assert_zero_plus_R2: assert (dbl_o == '0);
    end else begin
      assert_sign_R2: assert (dbl_o[DP_W-1] == int_i[INT_W-1]);
      assert_exp_range_R2: assert (dbl_o[DP_W-2:DP_FRAC_W] >= DP_EXP_W'(DP_BIAS) &&
                                   dbl_o[DP_W-2:DP_FRAC_W] <= DP_EXP_W'(DP_BIAS + INT_W - 1));
    end
  end
endmodule

// File: rtl/i2d_gate.sv
module i2d_gate
  import i2d_pkg::*;
(
  input  logic emul_i,
  input  logic osxs_i,
  input  logic feat_i,
  input  logic tsw_i,
  input  logic pend_i,
  output flt_e code_o
);
  logic [2:0] grant;
  logic       want_ud;

  always_comb begin
    want_ud  = emul_i | ~osxs_i | ~feat_i;
    grant[0] = want_ud;
    grant[1] = ~want_ud & tsw_i;
    grant[2] = ~want_ud & ~tsw_i & pend_i;
    unique case (1'b1)
      grant[0]: code_o = FLT_UNDEF;
      grant[1]: code_o = FLT_NODEV;
      grant[2]: code_o = FLT_FPPEND;
      default:  code_o = FLT_NONE;
    endcase
  end

  always_comb begin
    assert_single_grant_R8: assert ($onehot0(grant));
  end
endmodule

// File: rtl/i2d_pair_cvt.sv
module i2d_pair_cvt
  import i2d_pkg::*;
#(
  parameter int LANES = 2,
  parameter int INT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*INT_W-1:0] in_src,
  input  logic                   in_emul,
  input  logic                   in_osxs,
  input  logic                   in_feat,
  input  logic                   in_tsw,
  input  logic                   in_fp_pend,
  input  logic [STK_TOP_W-1:0]   in_stk_top,
  input  logic [STK_TAG_W-1:0]   in_stk_tag,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*DP_W-1:0]  out_res,
  output logic [STK_TOP_W-1:0]   out_stk_top,
  output logic [STK_TAG_W-1:0]   out_stk_tag,
  output logic [1:0]             out_fault
);
  localparam int RES_W = LANES * DP_W;

  logic [RES_W-1:0] lane_dbl;
  flt_e             code;
  logic             accept;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    i2d_lane #(.INT_W(INT_W)) u_lane (
      .int_i(in_src[g*INT_W +: INT_W]),
      .dbl_o(lane_dbl[g*DP_W +: DP_W])
    );
  end

  i2d_gate u_gate (
    .emul_i(in_emul),
    .osxs_i(in_osxs),
    .feat_i(in_feat),
    .tsw_i (in_tsw),
    .pend_i(in_fp_pend),
    .code_o(code)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_res     <= '0;
      out_stk_top <= '0;
      out_stk_tag <= '0;
      out_fault   <= FLT_NONE;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_fault <= code;
      if (code == FLT_NONE) begin
        out_res     <= lane_dbl;
        out_stk_top <= '0;
        out_stk_tag <= '0;
      end else begin
        out_res     <= '0;
        out_stk_top <= in_stk_top;
        out_stk_tag <= in_stk_tag;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_fault)
      && $stable(out_stk_top) && $stable(out_stk_tag));

  assert_fault_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault != FLT_NONE |-> out_res == '0);

  assert_stack_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault == FLT_NONE |-> out_stk_top == '0 && out_stk_tag == '0);

  assert_undef_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_emul || !in_osxs || !in_feat) |=> out_fault == FLT_UNDEF);

  assert_nodev_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_emul && in_osxs && in_feat && in_tsw |=> out_fault == FLT_NODEV);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
endmodule

// File: tb/tb_i2d_pair_cvt.sv
module tb_i2d_pair_cvt;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC = 3000;

  typedef struct packed {
    logic [127:0] res;
    logic [2:0]   top;
    logic [15:0]  tag;
    logic [1:0]   flt;
    logic [31:0]  lo;
    logic [31:0]  hi;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [63:0]  in_src = '0;
  logic         in_emul = 1'b0, in_osxs = 1'b1, in_feat = 1'b1, in_tsw = 1'b0, in_fp_pend = 1'b0;
  logic [2:0]   in_stk_top = '0;
  logic [15:0]  in_stk_tag = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_res;
  logic [2:0]   out_stk_top;
  logic [15:0]  out_stk_tag;
  logic [1:0]   out_fault;

  int n_tests = 0;
  int n_fail  = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2d_pair_cvt dut (.*);

  function automatic logic [63:0] ref_dbl(logic [31:0] v);
    int s;
    s = int'($signed(v));
    return $realtobits($itor(s));
  endfunction

  function automatic logic [1:0] ref_flt(logic e, logic o, logic f, logic t, logic p);
    if (e || !o || !f) return 2'd1;
    if (t) return 2'd2;
    if (p) return 2'd3;
    return 2'd0;
  endfunction

  function automatic exp_t build_exp();
    exp_t x;
    x.lo  = in_src[31:0];
    x.hi  = in_src[63:32];
    x.flt = ref_flt(in_emul, in_osxs, in_feat, in_tsw, in_fp_pend);
    if (x.flt == 2'd0) begin
      x.res = {ref_dbl(in_src[63:32]), ref_dbl(in_src[31:0])};
      x.top = '0;
      x.tag = '0;
    end else begin
      x.res = '0;
      x.top = in_stk_top;
      x.tag = in_stk_tag;
    end
    return x;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic string lane_tag(logic [31:0] v);
    if (v == 32'h8000_0000) return "R3";
    if (v == 32'h0) return "R2";
    return "R1 R2";
  endfunction

  task automatic compare_head();
    exp_t x;
    x = q.pop_front();
    check({lane_tag(x.lo), " low lane"}, {64'h0, out_res[63:0]}, {64'h0, x.res[63:0]});
    check({lane_tag(x.hi), " high lane"}, {64'h0, out_res[127:64]}, {64'h0, x.res[127:64]});
    check("R5 R6 R7 R8 fault code", 128'(out_fault), 128'(x.flt));
    check(x.flt == 2'd0 ? "R4 stack" : "R5 stack pass", 128'({out_stk_top, out_stk_tag}),
          128'({x.top, x.tag}));
  endtask

  task automatic drive_directed(int k);
    in_emul = 1'b0; in_osxs = 1'b1; in_feat = 1'b1; in_tsw = 1'b0; in_fp_pend = 1'b0;
    in_stk_top = 3'd5; in_stk_tag = 16'hA5C3;
    case (k)
      0: in_src = 64'h0;
      1: in_src = {32'h8000_0000, 32'h7FFF_FFFF};
      2: in_src = {32'hFFFF_FFFF, 32'h0000_0001};
      3: in_src = {32'h0000_0000, 32'h8000_0000};
      4: begin in_src = 64'h1234_5678_9ABC_DEF0; in_fp_pend = 1'b1; end
      5: begin in_src = 64'h1; in_tsw = 1'b1; in_fp_pend = 1'b1; end
      6: begin in_src = 64'h2; in_emul = 1'b1; in_tsw = 1'b1; end
      7: begin in_src = 64'h3; in_osxs = 1'b0; end
      8: begin in_src = 64'h4; in_feat = 1'b0; in_fp_pend = 1'b1; end
      default: in_src = {32'h0001_0000, 32'hFFFE_0000};
    endcase
  endtask

  task automatic drive_random();
    in_src     = {$urandom(), $urandom()};
    if ($urandom() % 4 == 0) in_src[31:0] = 32'h1 << ($urandom() % 32);
    if ($urandom() % 8 == 0) in_src[63:32] = 32'h8000_0000;
    in_emul    = ($urandom() % 8) == 0;
    in_osxs    = ($urandom() % 8) != 0;
    in_feat    = ($urandom() % 8) != 0;
    in_tsw     = ($urandom() % 8) == 0;
    in_fp_pend = ($urandom() % 6) == 0;
    in_stk_top = 3'($urandom());
    in_stk_tag = 16'($urandom());
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic pending;
    logic acc_last;
    int   dk;
    void'($urandom(32'd1357));
    pending  = 1'b0;
    acc_last = 1'b0;
    dk       = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset out_valid", 128'(out_valid), 128'(0));
    check("R9 reset in_ready", 128'(in_ready), 128'(1));
    rst_n = 1'b1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      if (acc_last) check("R10 one-cycle latency", 128'(out_valid), 128'(1));
      out_ready = (cyc < 20) ? 1'b1 : (($urandom() % 4) != 0);
      if (!pending) begin
        if (dk < 10) begin
          drive_directed(dk);
          dk++;
          in_valid = 1'b1;
        end else begin
          drive_random();
          in_valid = ($urandom() % 4) != 0;
        end
      end
      #1;
      // R9: ready rule at the port
      check("R9 in_ready", 128'(in_ready), 128'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (q.size() == 0) check("R10 unexpected output", 128'(1), 128'(0));
        else compare_head();
      end
      acc_last = in_valid && in_ready;
      if (acc_last) begin
        q.push_back(build_exp());
        pending = 1'b0;
      end else begin
        pending = in_valid;
      end
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    for (int d = 0; d < 8 && q.size() != 0; d++) begin
      #1;
      if (out_valid) compare_head();
      @(negedge clk);
    end
    check("R9 drain complete", 128'(q.size()), 128'(0));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule